// File: doc/BRIEF.md
# Scan-Accessed Trace Capture Buffer

This block records a stream of 20-bit trace words into a circular on-chip RAM. Software reaches it through a single serial data register that an external test access port drives with capture, shift and update strobes. Every scan carries one register access: a 32-bit value, a 7-bit register address and a write flag. Reads are pipelined. The value a read asks for is loaded into the data field at the next capture strobe, so it is shifted out during the following scan.

Capture is turned on through a control register. While capture is on, each valid trace beat lands at the write pointer and the pointer moves on. A wrapped flag records that the oldest entry now sits at the write pointer. A trigger input, together with a loadable down-counter, ends capture a programmed number of words after the trigger event. Stored words are read back through a data register. Each read of that register advances a read pointer that wraps at the RAM depth, so a dump of depth entries that starts at the write pointer returns the whole history in age order.

Top module: `trace_scan_buffer`

## Requirements
- R1: A scan frame is 40 bits, shifted in on `scan_tdi` and out on `scan_tdo` with the least significant bit first. Bits [31:0] hold the data, bits [38:32] hold the register address, and bit 39 is the write flag (1 = write, 0 = read). A 32-bit value written and then read back returns unchanged.
- R2: A read request at an update strobe returns its value in bits [31:0] of the frame that the next capture strobe loads. Bits [39:32] of a captured frame are zero.
- R3: The register map is: 0 identification (constant `ID_VALUE`), 1 RAM depth in words, 2 word width (20), 3 status, 4 RAM data, 5 read pointer, 6 write pointer, 7 trigger counter, 8 control. All of these read zero-extended to 32 bits.
- R4: Writes to addresses 0, 1 and 2 and to any address from 9 to 127 change nothing. Reads of addresses 9 to 127 return zero.
- R5: While control bit 0 is set, each cycle with `trace_valid` high stores `trace_word` (sync flag in bit 19, packet in bits 18:3, pipeline status in bits 2:0) at the write pointer. The pointer then increments modulo the depth. While the bit is clear, trace beats are ignored.
- R6: A read of the data register returns the entry at the read pointer, zero-extended, and advances the read pointer modulo the depth. No read of any other register moves the read pointer.
- R7: Status bit 1 is set when a capture moves the write pointer from depth-1 to 0. It stays set until status is written, and a status write clears status bits 0, 1 and 2.
- R8: `trace_trigger` high while capture is on sets status bit 2. After that cycle each captured word decrements the trigger counter. The capture that brings the counter to zero clears control bit 0 and sets status bit 0. A trigger that arrives with the counter at zero stops capture at once.
- R9: A write to the read or write pointer loads the low log2(depth) bits of the data. A write to the data register stores data bits [19:0] at the read pointer and advances the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_capture | input | 1 | Load pending read result into the scan register |
| scan_shift | input | 1 | Shift the scan register one bit toward `scan_tdo` |
| scan_update | input | 1 | Perform the access held in the scan register |
| scan_tdi | input | 1 | Serial data in |
| scan_tdo | output | 1 | Serial data out (scan register bit 0) |
| trace_valid | input | 1 | Trace beat present |
| trace_word | input | 20 | Trace beat contents |
| trace_trigger | input | 1 | Trigger event |

## Verification
Capture is exercised in short runs with capture on and then off, in a run long enough to wrap the RAM, and in a triggered run that ends after a programmed number of words. These cases separate a pointer that fails to advance, one that fails to wrap, and one that fails to stop. Dumps use back-to-back data reads as well as reads separated by identification reads. This tells the one-scan read latency and the single pointer advance per data read apart from double or missing advances. Writes to read-only and unimplemented addresses include an address whose low bits alias the control register, which exposes incomplete address decoding.

// File: rtl/trace_scan_pkg.sv
package trace_scan_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    localparam logic [ADDR_W-1:0] REG_ID    = 7'd0;
    localparam logic [ADDR_W-1:0] REG_SIZE  = 7'd1;
    localparam logic [ADDR_W-1:0] REG_WIDTH = 7'd2;
    localparam logic [ADDR_W-1:0] REG_STAT  = 7'd3;
    localparam logic [ADDR_W-1:0] REG_DATA  = 7'd4;
    localparam logic [ADDR_W-1:0] REG_RPTR  = 7'd5;
    localparam logic [ADDR_W-1:0] REG_WPTR  = 7'd6;
    localparam logic [ADDR_W-1:0] REG_TCNT  = 7'd7;
    localparam logic [ADDR_W-1:0] REG_CTRL  = 7'd8;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_req_t;
endpackage

// File: rtl/tsb_scan_shifter.sv
module tsb_scan_shifter
    import trace_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              shift_i,
    input  logic              upd_i,
    input  logic              tdi_i,
    input  logic [DATA_W-1:0] cap_data_i,
    output logic              tdo_o,
    output logic              req_valid_o,
    output scan_req_t         req_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } shift_st_t;

    shift_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap_i) begin
            s_d.sr = {{(FRAME_W-DATA_W){1'b0}}, cap_data_i};
        end else if (shift_i) begin
            s_d.sr = {tdi_i, s_q.sr[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tdo_o       = s_q.sr[0];
    assign req_valid_o = upd_i;
    assign req_o       = scan_req_t'(s_q.sr);
endmodule

// File: rtl/tsb_trace_ram.sv
module tsb_trace_ram #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 20
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [WORD_W-1:0]        wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [WORD_W-1:0]        rdata_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tsb_reg_bank.sv
module tsb_reg_bank
    import trace_scan_pkg::*;
#(
    parameter int          DEPTH    = 64,
    parameter int          WORD_W   = 20,
    parameter logic [31:0] ID_VALUE = 32'h7B5C_0001
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid_i,
    input  scan_req_t                req_i,
    input  logic                     trace_valid_i,
    input  logic [WORD_W-1:0]        trace_word_i,
    input  logic                     trigger_i,
    input  logic [WORD_W-1:0]        ram_rdata_i,
    output logic                     ram_we_o,
    output logic [$clog2(DEPTH)-1:0] ram_waddr_o,
    output logic [WORD_W-1:0]        ram_wdata_o,
    output logic [$clog2(DEPTH)-1:0] ram_raddr_o,
    output logic [DATA_W-1:0]        rd_result_o,
    output logic [$clog2(DEPTH)-1:0] wptr_o,
    output logic [$clog2(DEPTH)-1:0] rptr_o,
    output logic                     en_o,
    output logic                     wrapped_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]     rptr;
        logic [AW-1:0]     wptr;
        logic [DATA_W-1:0] tcount;
        logic              en;
        logic              wrapped;
        logic              done;
        logic              trig_seen;
        logic [DATA_W-1:0] rd_result;
    } bank_st_t;

    bank_st_t s_d, s_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    logic              scan_wr;
    logic              scan_rd;
    logic              capture;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        case (req_i.addr)
            REG_ID:    rd_mux = ID_VALUE;
            REG_SIZE:  rd_mux = 32'(DEPTH);
            REG_WIDTH: rd_mux = 32'(WORD_W);
            REG_STAT:  rd_mux = {29'b0, s_q.trig_seen, s_q.wrapped, s_q.done};
            REG_DATA:  rd_mux = 32'(ram_rdata_i);
            REG_RPTR:  rd_mux = 32'(s_q.rptr);
            REG_WPTR:  rd_mux = 32'(s_q.wptr);
            REG_TCNT:  rd_mux = s_q.tcount;
            REG_CTRL:  rd_mux = {31'b0, s_q.en};
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        scan_wr     = req_valid_i & req_i.wr;
        scan_rd     = req_valid_i & ~req_i.wr;
        capture     = s_q.en & trace_valid_i & ~(scan_wr & (req_i.addr == REG_DATA));
        ram_we_o    = 1'b0;
        ram_waddr_o = s_q.wptr;
        ram_wdata_o = trace_word_i;

        // trigger event
        if (trigger_i && s_q.en && !s_q.trig_seen) begin
            s_d.trig_seen = 1'b1;
            if (s_q.tcount == '0) begin
                s_d.en   = 1'b0;
                s_d.done = 1'b1;
            end
        end

        // trace capture
        if (capture) begin
            ram_we_o = 1'b1;
            s_d.wptr = ptr_inc(s_q.wptr);
            if (s_q.wptr == LAST) s_d.wrapped = 1'b1;
            if (s_q.trig_seen && s_q.tcount != '0) begin
                s_d.tcount = s_q.tcount - 1'b1;
                if (s_q.tcount == 32'd1) begin
                    s_d.en   = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end

        // scan read
        if (scan_rd) begin
            s_d.rd_result = rd_mux;
            if (req_i.addr == REG_DATA) s_d.rptr = ptr_inc(s_q.rptr);
        end

        // scan write, takes priority over capture effects
        if (scan_wr) begin
            case (req_i.addr)
                REG_STAT: begin
                    s_d.wrapped   = 1'b0;
                    s_d.done      = 1'b0;
                    s_d.trig_seen = 1'b0;
                end
                REG_DATA: begin
                    ram_we_o    = 1'b1;
                    ram_waddr_o = s_q.rptr;
                    ram_wdata_o = req_i.data[WORD_W-1:0];
                    s_d.rptr    = ptr_inc(s_q.rptr);
                end
                REG_RPTR: s_d.rptr   = req_i.data[AW-1:0];
                REG_WPTR: s_d.wptr   = req_i.data[AW-1:0];
                REG_TCNT: s_d.tcount = req_i.data;
                REG_CTRL: s_d.en     = req_i.data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ram_raddr_o = s_q.rptr;
    assign rd_result_o = s_q.rd_result;
    assign wptr_o      = s_q.wptr;
    assign rptr_o      = s_q.rptr;
    assign en_o        = s_q.en;
    assign wrapped_o   = s_q.wrapped;
endmodule

// File: rtl/trace_scan_buffer.sv
module trace_scan_buffer
    import trace_scan_pkg::*;
#(
    parameter int          DEPTH    = 64,
    parameter int          WORD_W   = 20,
    parameter logic [31:0] ID_VALUE = 32'h7B5C_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_capture,
    input  logic              scan_shift,
    input  logic              scan_update,
    input  logic              scan_tdi,
    output logic              scan_tdo,
    input  logic              trace_valid,
    input  logic [WORD_W-1:0] trace_word,
    input  logic              trace_trigger
);
    localparam int AW = $clog2(DEPTH);

    logic              req_valid_w;
    scan_req_t         req_w;
    logic [DATA_W-1:0] rd_result_w;
    logic              ram_we_w;
    logic [AW-1:0]     ram_waddr_w;
    logic [AW-1:0]     ram_raddr_w;
    logic [WORD_W-1:0] ram_wdata_w;
    logic [WORD_W-1:0] ram_rdata_w;
    logic [AW-1:0]     wptr_w;
    logic [AW-1:0]     rptr_w;
    logic              en_w;
    logic              wrapped_w;

    tsb_scan_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (scan_capture),
        .shift_i     (scan_shift),
        .upd_i       (scan_update),
        .tdi_i       (scan_tdi),
        .cap_data_i  (rd_result_w),
        .tdo_o       (scan_tdo),
        .req_valid_o (req_valid_w),
        .req_o       (req_w)
    );

    tsb_reg_bank #(
        .DEPTH    (DEPTH),
        .WORD_W   (WORD_W),
        .ID_VALUE (ID_VALUE)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid_w),
        .req_i         (req_w),
        .trace_valid_i (trace_valid),
        .trace_word_i  (trace_word),
        .trigger_i     (trace_trigger),
        .ram_rdata_i   (ram_rdata_w),
        .ram_we_o      (ram_we_w),
        .ram_waddr_o   (ram_waddr_w),
        .ram_wdata_o   (ram_wdata_w),
        .ram_raddr_o   (ram_raddr_w),
        .rd_result_o   (rd_result_w),
        .wptr_o        (wptr_w),
        .rptr_o        (rptr_w),
        .en_o          (en_w),
        .wrapped_o     (wrapped_w)
    );

    tsb_trace_ram #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_ram (
        .clk     (clk),
        .we_i    (ram_we_w),
        .waddr_i (ram_waddr_w),
        .wdata_i (ram_wdata_w),
        .raddr_i (ram_raddr_w),
        .rdata_o (ram_rdata_w)
    );
endmodule

// File: rtl/trace_scan_buffer_chk.sv
module trace_scan_buffer_chk #(
    parameter int DEPTH = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     upd,
    input logic                     wr,
    input logic [6:0]               addr,
    input logic                     valid,
    input logic                     en,
    input logic [$clog2(DEPTH)-1:0] wptr,
    input logic [$clog2(DEPTH)-1:0] rptr,
    input logic                     wrapped
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic wr_hit;
    assign wr_hit = upd & wr;

    // R5: an accepted beat moves the write pointer by one, wrapping at depth
    p_wptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && valid && !wr_hit) |=>
            (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1)));

    // R5: with capture off and no pointer write the write pointer holds
    p_wptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_hit) |=> $stable(wptr));

    // R6: only data accesses or pointer writes move the read pointer
    p_rptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(upd && addr == 7'd4) && !(wr_hit && addr == 7'd5)) |=> $stable(rptr));

    // R6: a data read advances the read pointer by one modulo depth
    p_rptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr && addr == 7'd4) |=>
            (rptr == (($past(rptr) == LAST) ? '0 : $past(rptr) + 1'b1)));

    // R7: wrapped flag is sticky until a status write
    p_wrap_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !(wr_hit && addr == 7'd3)) |=> wrapped);

    // R7: capturing at the last slot sets the wrapped flag
    p_wrap_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && valid && !wr_hit && wptr == LAST) |=> wrapped);
endmodule

bind trace_scan_buffer trace_scan_buffer_chk #(.DEPTH(DEPTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (scan_update),
    .wr      (req_w.wr),
    .addr    (req_w.addr),
    .valid   (trace_valid),
    .en      (en_w),
    .wptr    (wptr_w),
    .rptr    (rptr_w),
    .wrapped (wrapped_w)
);

// File: tb/trace_scan_buffer_tb_top.sv
module trace_scan_buffer_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 16;
    localparam logic [31:0] ID         = 32'hA5C3_0011;

    localparam logic [6:0] A_ID = 7'd0, A_SIZE = 7'd1, A_WIDTH = 7'd2, A_STAT = 7'd3,
                           A_DATA = 7'd4, A_RPTR = 7'd5, A_WPTR = 7'd6, A_TCNT = 7'd7,
                           A_CTRL = 7'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_capture = 1'b0, scan_shift = 1'b0, scan_update = 1'b0, scan_tdi = 1'b0;
    logic        scan_tdo;
    logic        trace_valid = 1'b0;
    logic [19:0] trace_word = '0;
    logic        trace_trigger = 1'b0;

    int          checks = 0;
    int          failures = 0;
    logic [19:0] model [DEPTH];
    int          mwp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_scan_buffer #(.DEPTH(DEPTH), .WORD_W(20), .ID_VALUE(ID)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_capture  (scan_capture),
        .scan_shift    (scan_shift),
        .scan_update   (scan_update),
        .scan_tdi      (scan_tdi),
        .scan_tdo      (scan_tdo),
        .trace_valid   (trace_valid),
        .trace_word    (trace_word),
        .trace_trigger (trace_trigger)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_scan(input logic wr, input logic [6:0] a, input logic [31:0] d,
                           output logic [31:0] got, output logic [7:0] hi);
        logic [39:0] frame;
        frame = {wr, a, d};
        @(negedge clk);
        scan_capture = 1'b1;
        @(negedge clk);
        scan_capture = 1'b0;
        scan_shift = 1'b1;
        for (int i = 0; i < 40; i++) begin
            scan_tdi = frame[i];
            if (i < 32) got[i] = scan_tdo;
            else        hi[i-32] = scan_tdo;
            @(negedge clk);
        end
        scan_shift = 1'b0;
        scan_update = 1'b1;
        @(negedge clk);
        scan_update = 1'b0;
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [31:0] d);
        logic [31:0] g; logic [7:0] h;
        do_scan(1'b1, a, d, g, h);
    endtask

    task automatic read_reg(input logic [6:0] a, output logic [31:0] v);
        logic [31:0] g; logic [7:0] h;
        do_scan(1'b0, a, '0, g, h);
        do_scan(1'b0, A_ID, '0, v, h);
    endtask

    task automatic push_word(input logic [19:0] w, input logic stored);
        @(negedge clk);
        trace_valid = 1'b1;
        trace_word = w;
        @(negedge clk);
        trace_valid = 1'b0;
        if (stored) begin
            model[mwp] = w;
            mwp = (mwp + 1) % DEPTH;
        end
    endtask

    function automatic logic [19:0] gen(input int k);
        return 20'((k * 40503 + 977) ^ (k << 13));
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        read_reg(A_ID, v);    chk("R3 ident", v, ID);
        read_reg(A_SIZE, v);  chk("R3 depth", v, DEPTH);
        read_reg(A_WIDTH, v); chk("R3 width", v, 32'd20);
        read_reg(A_STAT, v);  chk("R3 status reset", v, 32'd0);
        read_reg(A_WPTR, v);  chk("R3 wptr reset", v, 32'd0);
        read_reg(A_CTRL, v);  chk("R5 ctrl reset", v, 32'd0);
    endtask

    task automatic t_frame_r1;
        logic [31:0] v; logic [31:0] g; logic [7:0] h;
        write_reg(A_TCNT, 32'hDEAD_BEEF);
        read_reg(A_TCNT, v); chk("R1 32-bit round trip", v, 32'hDEAD_BEEF);
        do_scan(1'b0, A_ID, '0, g, h);
        chk("R2 captured upper bits zero", {24'b0, h}, 32'd0);
        chk("R2 result one scan later", g, ID);
        write_reg(A_TCNT, 32'd0);
    endtask

    task automatic t_ignored_r4;
        logic [31:0] v;
        write_reg(A_ID, 32'h0);
        write_reg(A_SIZE, 32'd5);
        write_reg(A_WIDTH, 32'd7);
        write_reg(7'd9, 32'hFFFF_FFFF);
        write_reg(7'h48, 32'd1);
        write_reg(7'd127, 32'h1234_5678);
        read_reg(A_ID, v);    chk("R4 ident write ignored", v, ID);
        read_reg(A_SIZE, v);  chk("R4 depth write ignored", v, DEPTH);
        read_reg(A_WIDTH, v); chk("R4 width write ignored", v, 32'd20);
        read_reg(A_CTRL, v);  chk("R4 aliasing address ignored", v, 32'd0);
        read_reg(7'd9, v);    chk("R4 addr 9 reads zero", v, 32'd0);
        read_reg(7'd127, v);  chk("R4 addr 127 reads zero", v, 32'd0);
    endtask

    task automatic t_capture_r5;
        logic [31:0] v; logic [31:0] g; logic [7:0] h;
        write_reg(A_CTRL, 32'd1);
        for (int k = 0; k < 5; k++) push_word(gen(k), 1'b1);
        write_reg(A_CTRL, 32'd0);
        push_word(20'hFFFFF, 1'b0);
        read_reg(A_WPTR, v); chk("R5 wptr after 5 beats, disabled beat ignored", v, 32'd5);
        write_reg(A_RPTR, 32'd0);
        do_scan(1'b0, A_DATA, '0, g, h);
        for (int k = 0; k < 5; k++) begin
            do_scan(1'b0, (k == 4) ? A_ID : A_DATA, '0, g, h);
            chk("R6 back-to-back data read", g, 32'(model[k]));
        end
        read_reg(A_RPTR, v); chk("R6 rptr after 5 data reads", v, 32'd5);
        read_reg(A_RPTR, v); chk("R6 non-data reads keep rptr", v, 32'd5);
    endtask

    task automatic t_ptrwrite_r9;
        logic [31:0] v;
        write_reg(A_RPTR, 32'd2);
        write_reg(A_DATA, 32'hFFF1_2345);
        model[2] = 20'h12345;
        read_reg(A_RPTR, v); chk("R9 data write advances rptr", v, 32'd3);
        write_reg(A_RPTR, 32'd2);
        read_reg(A_DATA, v); chk("R9 data write stores low 20 bits", v, 32'h0001_2345);
        write_reg(A_WPTR, 32'h23);
        read_reg(A_WPTR, v); chk("R9 wptr write keeps low bits", v, 32'd3);
        write_reg(A_WPTR, 32'd5);
    endtask

    task automatic t_wrap_r7;
        logic [31:0] v; logic [31:0] g; logic [7:0] h;
        write_reg(A_CTRL, 32'd1);
        for (int k = 0; k < DEPTH; k++) push_word(gen(100 + k), 1'b1);
        write_reg(A_CTRL, 32'd0);
        read_reg(A_STAT, v); chk("R7 wrapped flag", v, 32'd2);
        read_reg(A_WPTR, v); chk("R5 wptr wraps modulo depth", v, 32'd5);
        write_reg(A_RPTR, 32'd5);
        do_scan(1'b0, A_DATA, '0, g, h);
        for (int k = 0; k < DEPTH; k++) begin
            do_scan(1'b0, (k == DEPTH - 1) ? A_ID : A_DATA, '0, g, h);
            chk("R6 oldest-first dump", g, 32'(model[(5 + k) % DEPTH]));
        end
        read_reg(A_RPTR, v); chk("R6 rptr back at start after full dump", v, 32'd5);
        write_reg(A_STAT, 32'd0);
        read_reg(A_STAT, v); chk("R7 status write clears", v, 32'd0);
    endtask

    task automatic t_trigger_r8;
        logic [31:0] v;
        write_reg(A_TCNT, 32'd3);
        write_reg(A_CTRL, 32'd1);
        @(negedge clk); trace_trigger = 1'b1;
        @(negedge clk); trace_trigger = 1'b0;
        for (int k = 0; k < 5; k++) push_word(gen(200 + k), k < 3);
        read_reg(A_STAT, v); chk("R8 done and triggered", v, 32'd5);
        read_reg(A_CTRL, v); chk("R8 capture stopped", v, 32'd0);
        read_reg(A_WPTR, v); chk("R8 three words after trigger", v, 32'd8);
        read_reg(A_TCNT, v); chk("R8 counter at zero", v, 32'd0);
        write_reg(A_RPTR, 32'd7);
        read_reg(A_DATA, v); chk("R8 last stored word", v, 32'(model[7]));
        write_reg(A_STAT, 32'd0);
        write_reg(A_CTRL, 32'd1);
        @(negedge clk); trace_trigger = 1'b1;
        @(negedge clk); trace_trigger = 1'b0;
        push_word(20'h0ABCD, 1'b0);
        read_reg(A_CTRL, v); chk("R8 zero count stops at trigger", v, 32'd0);
        read_reg(A_WPTR, v); chk("R8 no word stored after zero-count trigger", v, 32'd8);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all-R actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_frame_r1();
        t_ignored_r4();
        t_capture_r5();
        t_ptrwrite_r9();
        t_wrap_r7();
        t_trigger_r8();
        summary();
    end
endmodule